// File: doc/BRIEF.md
# Byte-Wide Sample Output Formatter

This block takes 14-bit conversion results, one per converter period, and places each one on an 8-bit output bus as two consecutive bytes. The high byte goes out first and the low byte second. The design runs on one clock at twice the converter rate. An internal phase flag splits each converter period into a lead half and a trail half. A sample is captured only in the lead half, and the words leave after a fixed delay of three converter periods. A small channel tag travels with each word, so a receiver that collects interleaved colour channels can sort the bytes it gets.

Samples are offered on a stream interface that has a valid qualifier and no ready. The fixed latency requires that the block never pushes back. A sample is taken whenever `smp_valid` is high during a lead-half cycle, and its position in the output stream is fixed at that moment. On the output side, `byte_valid` is a plain strobe with no handshake, and the receiver must accept every byte. An active-low enable puts the bus driver into high impedance without disturbing the pipeline.

Top module: `byte_formatter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `byte_valid` is 0, `conv_first` is 1 and the enabled bus carries 0.
- R2: `conv_first` is 1 in the first cycle after reset and inverts on every clock. A high value marks the lead (capture) half of a converter period.
- R3: A sample is captured only when `smp_valid` is high in a cycle where `conv_first` is 1. Inputs presented while `conv_first` is 0 have no effect on the output stream.
- R4: In a high-byte cycle, bus lines 7..0 carry sample bits 13..6.
- R5: In a low-byte cycle, bus lines 7..2 carry sample bits 5..0 and bus lines 1..0 are 0.
- R6: For a sample captured in cycle c, the high byte appears in cycle c+6 (three converter periods) and the low byte in cycle c+7.
- R7: `byte_valid` is 1 for both bytes of a captured sample and 0 for both byte slots of an empty lead half. `byte_hi` is 1 on the high byte and 0 on the low byte. The enabled bus carries 0 when `byte_valid` is 0.
- R8: `byte_tag` equals the `smp_tag` captured with the sample, on both of its bytes.
- R9: While `oe_n` is 1, `bus_oe` is 0 and the bus is high impedance in the same cycle. `byte_valid`, `byte_hi` and `byte_tag` keep their normal sequence.
- R10: Samples captured in consecutive converter periods leave back to back, in capture order, with no bubble and no back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the converter rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample qualifier, taken when `conv_first` is 1 |
| smp_data | input | 14 | Conversion result |
| smp_tag | input | 2 | Channel tag carried with the sample |
| oe_n | input | 1 | Output enable, active low |
| conv_first | output | 1 | High in the lead (capture) half of a converter period |
| bus_q | output | 8 | Byte bus, high impedance when disabled |
| bus_oe | output | 1 | Bus driver enable |
| byte_valid | output | 1 | Current byte belongs to a captured sample |
| byte_hi | output | 1 | Current byte is the high byte |
| byte_tag | output | 2 | Channel tag of the current byte |

## Verification
The bench targets the exact six-cycle offset between capture and high byte. A pipeline that is one stage short or long shifts every word by a converter period, so the wrong sample shows up with the wrong tag. It presents junk with the valid qualifier set during trail halves; a design that samples on both phases would corrupt the following word. Values that fill only the top or only the bottom bits check the 8+6 split: a wrong shift or non-zero padding on lines 1..0 changes the low byte. Gaps between samples and toggling of the output enable show whether empty slots and the high-impedance state leak into the strobe or the data.

// File: rtl/fmtr_pkg.sv
package fmtr_pkg;
  // Half of a converter period: lead captures, trail completes the byte pair.
  typedef enum logic {PH_LEAD = 1'b0, PH_TRAIL = 1'b1} phase_e;
endpackage

// File: rtl/fmtr_phase.sv
module fmtr_phase
  import fmtr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e ph
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_LEAD;
    else        ph <= (ph == PH_LEAD) ? PH_TRAIL : PH_LEAD;
  end
endmodule

// File: rtl/fmtr_delay.sv
module fmtr_delay #(
  parameter int DW    = 16,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          in_v,
  input  logic [DW-1:0] in_d,
  output logic          out_v,
  output logic [DW-1:0] out_d
);
  logic          st_v [DEPTH];
  logic [DW-1:0] st_d [DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_v[j] <= 1'b0;
        st_d[j] <= '0;
      end else if (adv) begin
        if (j == 0) begin
          st_v[j] <= in_v;
          st_d[j] <= in_v ? in_d : '0;
        end else begin
          st_v[j] <= st_v[j-1];
          st_d[j] <= st_d[j-1];
        end
      end
    end
  end

  assign out_v = st_v[DEPTH-1];
  assign out_d = st_d[DEPTH-1];
endmodule

// File: rtl/fmtr_split.sv
module fmtr_split
  import fmtr_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int BUS_W    = 8,
  parameter int TAG_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  phase_e              ph,
  input  logic                st_v,
  input  logic [TAG_W-1:0]    st_tag,
  input  logic [SAMPLE_W-1:0] st_data,
  output logic [BUS_W-1:0]    byte_q,
  output logic                byte_v,
  output logic                byte_hi,
  output logic [TAG_W-1:0]    byte_tag
);
  localparam int LO_W  = SAMPLE_W - BUS_W;
  localparam int PAD_W = BUS_W - LO_W;

  logic [BUS_W-1:0] hi_part, lo_part;
  assign hi_part = st_data[SAMPLE_W-1 -: BUS_W];
  assign lo_part = {st_data[LO_W-1:0], {PAD_W{1'b0}}};

  // Edge closing a trail half loads the high byte, edge closing a lead
  // half loads the low byte of the same stage word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q   <= '0;
      byte_v   <= 1'b0;
      byte_hi  <= 1'b0;
      byte_tag <= '0;
    end else begin
      byte_v   <= st_v;
      byte_tag <= st_v ? st_tag : '0;
      byte_hi  <= (ph == PH_TRAIL);
      if (!st_v)              byte_q <= '0;
      else if (ph == PH_TRAIL) byte_q <= hi_part;
      else                     byte_q <= lo_part;
    end
  end
endmodule

// File: rtl/byte_formatter.sv
module byte_formatter
  import fmtr_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int BUS_W    = 8,
  parameter int TAG_W    = 2,
  parameter int LATENCY  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [TAG_W-1:0]    smp_tag,
  input  logic                oe_n,
  output logic                conv_first,
  output logic [BUS_W-1:0]    bus_q,
  output logic                bus_oe,
  output logic                byte_valid,
  output logic                byte_hi,
  output logic [TAG_W-1:0]    byte_tag
);
  localparam int WORD_W = TAG_W + SAMPLE_W;

  phase_e             ph;
  logic               dl_v;
  logic [WORD_W-1:0]  dl_d;
  logic [BUS_W-1:0]   byte_q;

  fmtr_phase u_phase (.clk(clk), .rst_n(rst_n), .ph(ph));

  assign conv_first = (ph == PH_LEAD);

  fmtr_delay #(.DW(WORD_W), .DEPTH(LATENCY)) u_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (conv_first),
    .in_v  (smp_valid),
    .in_d  ({smp_tag, smp_data}),
    .out_v (dl_v),
    .out_d (dl_d)
  );

  fmtr_split #(.SAMPLE_W(SAMPLE_W), .BUS_W(BUS_W), .TAG_W(TAG_W)) u_split (
    .clk      (clk),
    .rst_n    (rst_n),
    .ph       (ph),
    .st_v     (dl_v),
    .st_tag   (dl_d[WORD_W-1 -: TAG_W]),
    .st_data  (dl_d[SAMPLE_W-1:0]),
    .byte_q   (byte_q),
    .byte_v   (byte_valid),
    .byte_hi  (byte_hi),
    .byte_tag (byte_tag)
  );

  assign bus_oe = ~oe_n;
  assign bus_q  = bus_oe ? byte_q : {BUS_W{1'bz}};
endmodule

// File: rtl/byte_formatter_chk.sv
module byte_formatter_chk #(
  parameter int BUS_W   = 8,
  parameter int TAG_W   = 2,
  parameter int LATENCY = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic             oe_n,
  input logic             conv_first,
  input logic             bus_oe,
  input logic [BUS_W-1:0] bus_q,
  input logic [BUS_W-1:0] byte_q,
  input logic             byte_valid,
  input logic             byte_hi,
  input logic [TAG_W-1:0] byte_tag
);
  localparam int WIN = 2 * LATENCY + 1;
  logic [WIN-1:0] cap_hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_hist <= '0;
    else        cap_hist <= {cap_hist[WIN-2:0], smp_valid & conv_first};
  end

  a_r2_phase_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    conv_first |=> !conv_first);
  a_r2_phase_returns: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_first |=> conv_first);
  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid == (cap_hist[WIN-2] | cap_hist[WIN-1]));
  a_r7_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && byte_hi) |=> (byte_valid && !byte_hi));
  a_r8_tag_held: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && byte_hi) |=> (byte_tag == $past(byte_tag)));
  a_r5_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_hi && bus_oe) |-> (bus_q[1:0] == 2'b00));
  a_r9_enable: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe == !oe_n);
  a_r9_drive: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (bus_q == byte_q));
endmodule

bind byte_formatter byte_formatter_chk #(.BUS_W(BUS_W), .TAG_W(TAG_W), .LATENCY(LATENCY)) chk_i (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .oe_n(oe_n),
  .conv_first(conv_first), .bus_oe(bus_oe), .bus_q(bus_q), .byte_q(byte_q),
  .byte_valid(byte_valid), .byte_hi(byte_hi), .byte_tag(byte_tag)
);

// File: tb/byte_formatter_tb_top.sv
module byte_formatter_tb_top;
  localparam int NCYC = 900;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [13:0] smp_data = '0;
  logic [1:0]  smp_tag = '0;
  logic        oe_n = 1'b0;
  logic        conv_first, bus_oe, byte_valid, byte_hi;
  logic [7:0]  bus_q;
  logic [1:0]  byte_tag;

  int errors = 0;
  int checks = 0;

  logic        h_v [NCYC];
  logic [13:0] h_d [NCYC];
  logic [1:0]  h_t [NCYC];

  always #2 clk = ~clk;

  byte_formatter dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_tag(smp_tag), .oe_n(oe_n), .conv_first(conv_first), .bus_q(bus_q),
    .bus_oe(bus_oe), .byte_valid(byte_valid), .byte_hi(byte_hi), .byte_tag(byte_tag)
  );

  function automatic logic [7:0] f_hi(logic [13:0] d);
    return d[13:6];
  endfunction
  function automatic logic [7:0] f_lo(logic [13:0] d);
    return {d[5:0], 2'b00};
  endfunction

  task automatic chk(string req, int cyc, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic check_cycle(int c);
    bit ev, ehi;
    int k;
    chk("R2", c, conv_first, (c % 2 == 0));
    chk("R9", c, bus_oe, !oe_n);
    ev = 1'b0; k = 0;
    if (c >= 6) begin
      k  = (c % 2 == 0) ? c - 6 : c - 7;
      ev = h_v[k];
    end
    ehi = (c % 2 == 0);
    if (c == 0) chk("R1", c, byte_valid, 0);
    chk(ev ? "R6" : "R7", c, byte_valid, ev);
    if (ev) begin
      chk("R7", c, byte_hi, ehi);
      chk("R8", c, byte_tag, h_t[k]);
      if (!oe_n) begin
        if (ehi) chk("R4", c, bus_q, f_hi(h_d[k]));
        else     chk("R5", c, bus_q, f_lo(h_d[k]));
      end
    end else if (!oe_n) begin
      chk("R7", c, bus_q, 8'h00);
    end
  endtask

  task automatic drive_cycle(int c);
    logic [13:0] d;
    logic        v;
    d = 14'($urandom);
    v = ($urandom % 5) != 0;
    oe_n <= (c > 40) && (($urandom % 8) == 0);
    if (c % 2 == 1) begin
      // R3: junk offered in a trail half must not reach the output
      v = 1'b1;
    end else begin
      case (c)
        0:  d = 14'h3FFF;
        2:  d = 14'h0000;
        4:  d = 14'h2AAA;
        6:  d = 14'h003F;
        8:  d = 14'h3FC0;
        10: v = 1'b0;
        12: d = 14'h0001;
        14: d = 14'h2000;
        default: ;
      endcase
      if (c <= 8 || c == 12 || c == 14) v = 1'b1;
      if (c >= 20 && c < 60) v = 1'b1;  // R10: unbroken run
    end
    smp_valid <= v;
    smp_data  <= d;
    smp_tag   <= 2'((c / 2) % 3);
    h_v[c] = v && (c % 2 == 0);
    h_d[c] = d;
    h_t[c] = 2'((c / 2) % 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) begin
      @(negedge clk);
      chk("R1", -1, byte_valid, 0);
      chk("R1", -1, conv_first, 1);
      chk("R1", -1, bus_q, 8'h00);
    end
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < NCYC; c++) begin
      if (c > 0) @(negedge clk);
      check_cycle(c);
      if (c < NCYC - 8) drive_cycle(c);
      else begin
        smp_valid <= 1'b0;
        h_v[c] = 1'b0;
        h_d[c] = '0;
        h_t[c] = '0;
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule